// File: doc/BRIEF.md
# Serial Configuration Image Loader

This block runs once after reset. It acts as the master side of a serial EEPROM read. It takes the bytes that a byte-level serial reader delivers and turns them into register writes. The image starts with a byte that gives the number of configuration blocks. Each block has a four-byte header that holds a 10-bit word count and a 22-bit word address. The header is followed by the block's 32-bit data words. A 16-bit checksum over every byte before it closes the image.

Words are written one after another. Each word goes to the address four bytes above the previous one. At the end, the block compares its own CRC-16 with the stored value. It then raises a completion flag, and an error flag when the check fails. From then on it no longer acts as master, so the serial interface can return to slave operation. The block also gives the serial engine a divider value for the master clock rate. One select input chooses between the fast rate and the standard rate.

Top module: `eel_loader`

## Requirements
- R1: After reset, wr_en, load_done and crc_err are 0 and mst_mode is 1.
- R2: The first image byte is the block count N. Each block header is four bytes h0..h3 with these fields:
  - count[7:0] = h0
  - count[9:8] = h1[7:6]
  - waddr[5:0] = h1[5:0]
  - waddr[13:6] = h2
  - waddr[21:14] = h3
  - The first word of the block is written at byte address {waddr, 2'b00}.
- R3: A block carries count+1 data words, written in turn at byte addresses base, base+4, base+8 and so on. A count that uses bits 8 and 9 is honoured in full.
- R4: Each data word is assembled from four bytes, most significant byte first. wr_en pulses for exactly one cycle, in the cycle after the fourth byte is accepted.
- R5: The CRC has polynomial 0x8005 (x16+x15+x2+1) and seed 0. Each byte is shifted in most significant bit first, and no zero padding is appended. It covers every byte before the final two. The stored CRC comes high byte first.
- R6: load_done rises in the cycle after the final CRC byte is accepted. crc_err is 1 with it exactly when the computed and stored CRC differ. Both stay set until reset.
- R7: A CRC mismatch does not suppress or undo any write already issued. Every word of the image appears on the write port.
- R8: If in_done is seen in a cycle that does not carry the final CRC byte, load_done and crc_err are both 1 in the next cycle.
- R9: Once load_done is 1, mst_mode is 0. Further input bytes cause no writes and leave both flags unchanged.
- R10: scl_div equals DIV_FAST when clk_slow_sel is 0 and DIV_SLOW when it is 1.
- R11: A block count of 0 makes the image just that byte followed by the two CRC bytes. No writes are issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A byte from the serial reader is present |
| in_byte | input | 8 | Byte from the serial reader |
| in_done | input | 1 | Reader has finished the stream |
| clk_slow_sel | input | 1 | Master clock rate: 0 selects the fast rate, 1 the standard rate |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 24 | Register byte address |
| wr_data | output | 32 | Register write data |
| load_done | output | 1 | Load finished, whether good or failed |
| crc_err | output | 1 | Load failed: CRC mismatch or early end |
| mst_mode | output | 1 | Block is acting as serial master |
| scl_div | output | 16 | Half-period divider for the master clock |

## Verification
The hardest case to reach is a block count whose bits 8 and 9 are set, because it needs an image of more than 256 words in one block. The bench builds such a block: 301 words at a word address whose low six bits are all ones. This exercises both split fields of the second header byte. Random gaps between bytes check that byte timing has no effect. Corrupted checksums, an early end-of-stream and trailing bytes after completion drive the failure and ignore paths.

// File: rtl/eel_pkg.sv
package eel_pkg;
    localparam int BYTE_W   = 8;
    localparam int WORD_W   = 32;
    localparam int CNT_W    = 10;
    localparam int WADDR_W  = 22;
    localparam int BADDR_W  = WADDR_W + 2;
    localparam int CRC_W    = 16;
    localparam int NBLK_W   = 8;
    localparam int BIDX_W   = $clog2(WORD_W / BYTE_W);
    localparam logic [CRC_W-1:0] CRC_POLY = 16'h8005;

    typedef enum logic [2:0] {
        ST_NBLK,
        ST_HDR,
        ST_DATA,
        ST_CRC_HI,
        ST_CRC_LO,
        ST_END
    } ld_state_e;

    typedef struct packed {
        logic [CNT_W-1:0]   cnt;
        logic [WADDR_W-1:0] waddr;
    } blk_hdr_t;

    typedef struct packed {
        logic               en;
        logic [BADDR_W-1:0] addr;
        logic [WORD_W-1:0]  data;
    } reg_wr_t;

    // Direct (non-augmented) CRC step over one byte, MSB first
    function automatic logic [CRC_W-1:0] crc16_byte(input logic [CRC_W-1:0] c,
                                                    input logic [BYTE_W-1:0] b);
        logic [CRC_W-1:0] r;
        r = c;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            if (r[CRC_W-1] ^ b[i]) r = (r << 1) ^ CRC_POLY;
            else                   r = r << 1;
        end
        return r;
    endfunction

    // raw holds the header bytes h0..h3 with h0 in the top byte
    function automatic blk_hdr_t hdr_decode(input logic [WORD_W-1:0] raw);
        blk_hdr_t h;
        h.cnt   = {raw[23:22], raw[31:24]};
        h.waddr = {raw[7:0], raw[15:8], raw[21:16]};
        return h;
    endfunction
endpackage

// File: rtl/eel_crc16.sv
module eel_crc16
    import eel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              upd,
    input  logic [BYTE_W-1:0] din,
    output logic [CRC_W-1:0]  crc
);
    always_ff @(posedge clk) begin
        if (rst)      crc <= '0;
        else if (upd) crc <= crc16_byte(crc, din);
    end
endmodule

// File: rtl/eel_word_asm.sv
module eel_word_asm
    import eel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [BYTE_W-1:0] din,
    output logic [WORD_W-1:0] word_now,
    output logic              last
);
    logic [WORD_W-1:0] sh;
    logic [BIDX_W-1:0] idx;

    assign word_now = {sh[WORD_W-BYTE_W-1:0], din};
    assign last     = take && (idx == BIDX_W'((WORD_W / BYTE_W) - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sh  <= '0;
            idx <= '0;
        end else if (take) begin
            sh  <= word_now;
            idx <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/eel_parser.sv
module eel_parser
    import eel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_done,
    input  logic [CRC_W-1:0]  crc_now,
    input  logic [WORD_W-1:0] asm_word,
    input  logic              asm_last,
    output logic              crc_upd,
    output logic              asm_take,
    output reg_wr_t           wr,
    output logic              done,
    output logic              err
);
    ld_state_e           state;
    blk_hdr_t            hdr;
    logic [CNT_W-1:0]    wcnt;
    logic [NBLK_W-1:0]   blk_left;
    logic [BYTE_W-1:0]   crc_hi;
    logic                byte_ok;

    assign byte_ok  = in_valid && !in_done && (state != ST_END);
    assign crc_upd  = byte_ok && (state == ST_NBLK || state == ST_HDR || state == ST_DATA);
    assign asm_take = byte_ok && (state == ST_HDR || state == ST_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_NBLK;
            hdr      <= '0;
            wcnt     <= '0;
            blk_left <= '0;
            crc_hi   <= '0;
            wr       <= '0;
            done     <= 1'b0;
            err      <= 1'b0;
        end else begin
            wr.en <= 1'b0;
            if (state != ST_END) begin
                if (in_valid && state == ST_CRC_LO) begin
                    done  <= 1'b1;
                    err   <= ({crc_hi, in_byte} != crc_now);
                    state <= ST_END;
                end else if (in_done) begin
                    done  <= 1'b1;
                    err   <= 1'b1;
                    state <= ST_END;
                end else if (in_valid) begin
                    unique case (state)
                        ST_NBLK: begin
                            blk_left <= in_byte;
                            state    <= (in_byte == '0) ? ST_CRC_HI : ST_HDR;
                        end
                        ST_HDR: begin
                            if (asm_last) begin
                                hdr   <= hdr_decode(asm_word);
                                wcnt  <= '0;
                                state <= ST_DATA;
                            end
                        end
                        ST_DATA: begin
                            if (asm_last) begin
                                wr.en     <= 1'b1;
                                wr.addr   <= {hdr.waddr, 2'b00};
                                wr.data   <= asm_word;
                                hdr.waddr <= hdr.waddr + 1'b1;
                                wcnt      <= wcnt + 1'b1;
                                if (wcnt == hdr.cnt) begin
                                    blk_left <= blk_left - 1'b1;
                                    state    <= (blk_left == NBLK_W'(1)) ? ST_CRC_HI : ST_HDR;
                                end
                            end
                        end
                        ST_CRC_HI: begin
                            crc_hi <= in_byte;
                            state  <= ST_CRC_LO;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/eel_loader.sv
module eel_loader
    import eel_pkg::*;
#(
    parameter int DIV_W    = 16,
    parameter int DIV_FAST = 156,
    parameter int DIV_SLOW = 625
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [BYTE_W-1:0]  in_byte,
    input  logic               in_done,
    input  logic               clk_slow_sel,
    output logic               wr_en,
    output logic [BADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0]  wr_data,
    output logic               load_done,
    output logic               crc_err,
    output logic               mst_mode,
    output logic [DIV_W-1:0]   scl_div
);
    localparam logic [DIV_W-1:0] DIV_F = DIV_W'(DIV_FAST);
    localparam logic [DIV_W-1:0] DIV_S = DIV_W'(DIV_SLOW);

    logic              crc_upd;
    logic [CRC_W-1:0]  crc_now;
    logic              asm_take;
    logic              asm_last;
    logic [WORD_W-1:0] asm_word;
    reg_wr_t           wr;

    eel_crc16 u_crc (
        .clk (clk),
        .rst (rst),
        .upd (crc_upd),
        .din (in_byte),
        .crc (crc_now)
    );

    eel_word_asm u_asm (
        .clk      (clk),
        .rst      (rst),
        .take     (asm_take),
        .din      (in_byte),
        .word_now (asm_word),
        .last     (asm_last)
    );

    eel_parser u_prs (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .in_done  (in_done),
        .crc_now  (crc_now),
        .asm_word (asm_word),
        .asm_last (asm_last),
        .crc_upd  (crc_upd),
        .asm_take (asm_take),
        .wr       (wr),
        .done     (load_done),
        .err      (crc_err)
    );

    assign wr_en    = wr.en;
    assign wr_addr  = wr.addr;
    assign wr_data  = wr.data;
    assign mst_mode = ~load_done;
    assign scl_div  = clk_slow_sel ? DIV_S : DIV_F;
endmodule

// File: rtl/eel_loader_chk.sv
module eel_loader_chk (
    input logic clk,
    input logic rst,
    input logic wr_en,
    input logic load_done,
    input logic crc_err
);
    AST_DONE_STICKY:   assert property (@(posedge clk) disable iff (rst) load_done |=> load_done); // R6
    AST_ERR_STICKY:    assert property (@(posedge clk) disable iff (rst) crc_err |=> crc_err); // R6
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst) crc_err |-> load_done); // R8
    AST_WR_ONE_CYCLE:  assert property (@(posedge clk) disable iff (rst) wr_en |=> !wr_en); // R4
    AST_NO_WR_AFTER:   assert property (@(posedge clk) disable iff (rst) load_done |=> !wr_en); // R9
endmodule

bind eel_loader eel_loader_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .load_done (load_done),
    .crc_err   (crc_err)
);

// File: tb/eel_loader_bench.sv
`timescale 1ns/1ps
module eel_loader_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [7:0]  in_byte;
    logic        in_done;
    logic        clk_slow_sel;
    logic        wr_en;
    logic [23:0] wr_addr;
    logic [31:0] wr_data;
    logic        load_done;
    logic        crc_err;
    logic        mst_mode;
    logic [15:0] scl_div;

    always #4 clk = ~clk;

    eel_loader u_eel_loader (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .in_done(in_done), .clk_slow_sel(clk_slow_sel), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .load_done(load_done),
        .crc_err(crc_err), .mst_mode(mst_mode), .scl_div(scl_div)
    );

    int total = 0;
    int bad   = 0;
    bit fin   = 0;

    logic [7:0]  img [0:2047];
    int          img_len;
    logic [23:0] exp_addr [0:1023];
    logic [31:0] exp_data [0:1023];
    int          exp_n;
    int          got_n;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // R4 R3 R2: each write compared with the expected list
    always @(negedge clk) begin
        if (!rst && wr_en) begin
            if (got_n < 1024) begin
                chk(wr_addr == exp_addr[got_n], "R3", "write address", wr_addr, exp_addr[got_n]);
                chk(wr_data == exp_data[got_n], "R4", "write data", wr_data, exp_data[got_n]);
            end
            got_n++;
        end
    end

    function automatic logic [15:0] ref_crc(input int n);
        logic [15:0] c = 16'h0000;
        for (int i = 0; i < n; i++) begin
            for (int k = 7; k >= 0; k--) begin
                logic fb = c[15] ^ img[i][k];
                c = {c[14:0], 1'b0};
                if (fb) c = c ^ 16'h8005;
            end
        end
        return c;
    endfunction

    task automatic push(input logic [7:0] b);
        img[img_len] = b;
        img_len++;
    endtask

    task automatic img_start(input logic [7:0] nblk);
        img_len = 0;
        exp_n   = 0;
        push(nblk);
    endtask

    task automatic add_block(input logic [9:0] cnt, input logic [21:0] wa);
        push(cnt[7:0]);
        push({cnt[9:8], wa[5:0]});
        push(wa[13:6]);
        push(wa[21:14]);
        for (int i = 0; i <= int'(cnt); i++) begin
            logic [31:0] d = $urandom;
            logic [21:0] a = wa + 22'(i);
            push(d[31:24]); push(d[23:16]); push(d[15:8]); push(d[7:0]);
            exp_addr[exp_n] = {a, 2'b00};
            exp_data[exp_n] = d;
            exp_n++;
        end
    endtask

    task automatic img_close(input logic [15:0] flip);
        logic [15:0] c = ref_crc(img_len) ^ flip;
        push(c[15:8]);
        push(c[7:0]);
    endtask

    task automatic send(input int first, input int n);
        for (int i = first; i < first + n; i++) begin
            repeat ($urandom % 3) @(negedge clk);
            in_valid = 1'b1;
            in_byte  = img[i];
            @(negedge clk);
            in_valid = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; in_done = 1'b0; in_byte = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        got_n = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1; in_valid = 1'b0; in_done = 1'b0; in_byte = '0; clk_slow_sel = 1'b0;
        got_n = 0;
        do_reset();
        chk(wr_en == 1'b0, "R1", "wr_en at reset", wr_en, 0);
        chk(load_done == 1'b0, "R1", "load_done at reset", load_done, 0);
        chk(crc_err == 1'b0, "R1", "crc_err at reset", crc_err, 0);
        chk(mst_mode == 1'b1, "R1", "mst_mode at reset", mst_mode, 1);

        // R10 divider select
        clk_slow_sel = 1'b0; #1;
        chk(scl_div == 16'd156, "R10", "fast divider", scl_div, 156);
        clk_slow_sel = 1'b1; #1;
        chk(scl_div == 16'd625, "R10", "slow divider", scl_div, 625);

        // R3 single word block
        img_start(8'd1); add_block(10'd0, 22'h12345); img_close(16'h0);
        send(0, img_len);
        chk(load_done && !crc_err, "R6", "single word good load", {load_done, crc_err}, 2'b10);
        chk(got_n == exp_n, "R3", "single word count", got_n, exp_n);
        chk(mst_mode == 1'b0, "R9", "master released", mst_mode, 0);
        // R9 trailing bytes ignored
        send(0, img_len);
        chk(got_n == exp_n, "R9", "no writes after done", got_n, exp_n);
        chk(load_done && !crc_err, "R9", "flags unchanged after trailing bytes", {load_done, crc_err}, 2'b10);

        // R2 R3 large count with split high bits, low address bits all ones
        do_reset();
        img_start(8'd2); add_block(10'd300, 22'h2A_AAFF | 22'h3F); add_block(10'd2, 22'h00040);
        img_close(16'h0);
        send(0, img_len);
        chk(got_n == exp_n, "R2", "large block word count", got_n, exp_n);
        chk(load_done && !crc_err, "R5", "large image CRC good", {load_done, crc_err}, 2'b10);

        // random images
        for (int r = 0; r < 4; r++) begin
            int nb = 1 + ($urandom % 4);
            do_reset();
            img_start(8'(nb));
            for (int b = 0; b < nb; b++) add_block(10'($urandom % 6), 22'($urandom));
            img_close(16'h0);
            send(0, img_len);
            chk(got_n == exp_n, "R3", "random image word count", got_n, exp_n);
            chk(load_done && !crc_err, "R5", "random image CRC good", {load_done, crc_err}, 2'b10);
        end

        // R7 bad CRC still has all writes
        do_reset();
        img_start(8'd2); add_block(10'd3, 22'h0ABCD); add_block(10'd1, 22'h3FFFE);
        img_close(16'h0100);
        send(0, img_len);
        chk(load_done && crc_err, "R6", "mismatch flagged", {load_done, crc_err}, 2'b11);
        chk(got_n == exp_n, "R7", "writes kept on mismatch", got_n, exp_n);
        send(0, 4);
        chk(crc_err == 1'b1, "R6", "error sticky", crc_err, 1);

        // R11 empty image
        do_reset();
        img_start(8'd0); img_close(16'h0);
        send(0, img_len);
        chk(load_done && !crc_err, "R11", "empty image", {load_done, crc_err}, 2'b10);
        chk(got_n == 0, "R11", "empty image writes", got_n, 0);

        // R8 early end of stream
        do_reset();
        img_start(8'd1); add_block(10'd1, 22'h00100); img_close(16'h0);
        send(0, 9);
        chk(load_done == 1'b0, "R8", "not done before end", load_done, 0);
        in_done = 1'b1; @(negedge clk); in_done = 1'b0;
        chk(load_done && crc_err, "R8", "early end fails", {load_done, crc_err}, 2'b11);
        chk(got_n == 1, "R8", "writes before early end", got_n, 1);
        chk(mst_mode == 1'b0, "R9", "master released after failure", mst_mode, 0);

        fin = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule